// File: doc/BRIEF.md
# Trip Threshold Reset Sequencer

This block sits behind a serial-bus byte decoder and drives the reprogramming of three stored voltage-trip threshold codes. It receives START and STOP events, a strobe with each received byte, and the level of a shared pin that reports whether the programming voltage is present. A command counts only when that flag is already high in the START cycle. The command is the write device byte, then a byte that selects one threshold, then one data byte. A data byte of zero resets the selected threshold to its minimum code, the code that stands for the lowest trip voltage. A nonzero data byte can only raise the threshold. A threshold is therefore lowered by a reset followed by a raise.

A valid command does not act until STOP. STOP puts the block into a busy phase in which it holds a one-hot programming request for the chosen threshold. The busy phase ends only when the programming flag is later seen low. At that point the stored code is written and a one-cycle completion strobe is given. The block gives every received byte an acknowledge or a not-acknowledge answer. Nothing outside the three threshold registers is written.

Top module: `tt_reset_seq`

## Requirements
- R1: After reset: `busy_o`, `done_o`, `ack_o`, `nack_o` and `prog_req_o` are all 0, and each of the three threshold codes in `thr_codes_o` equals `INIT_CODE`. Threshold k occupies bits [k*CW +: CW].
- R2: A transaction is armed only if `vp_flag` is 1 in the cycle where `start_evt` is 1. If it is not armed, every byte up to the next START is answered with nack, and a STOP does not start programming, even if `vp_flag` rises after START.
- R3: In an armed transaction, the first byte must be A0h, which is acked. Any other value is nacked, and the rest of that transaction is ignored.
- R4: The second byte selects the threshold: 03h selects threshold 0, 0Bh selects threshold 1 and 0Fh selects threshold 2, each acked. Any other value is nacked, and the transaction is ignored.
- R5: A data byte of 00h is acked and marks a reset. On the STOP that follows, `busy_o` is 1 and `prog_req_o` has only the bit of the selected threshold set, both from the cycle after STOP.
- R6: While busy, the block waits until `vp_flag` is sampled 0. In the next cycle `done_o` is 1 for exactly one cycle, `busy_o` and `prog_req_o` are 0, and the selected threshold holds the new code: 0 after a reset.
- R7: A nonzero data byte d is acked only if d ≤ 2^CW−1 and d ≥ the present code of the selected threshold. It then programs code d on completion. Otherwise it is nacked, and no programming follows.
- R8: A STOP that arrives before an accepted data byte returns the block to idle. No threshold changes and `busy_o` stays 0.
- R9: While busy, START events are ignored and every byte is nacked. `busy_o` stays 1 as long as `vp_flag` stays 1.
- R10: Bytes after an accepted data byte are nacked, but the accepted command still runs on STOP. Completion changes only the selected threshold. Thresholds never change except in the cycle `done_o` is 1.
- R11: Each byte strobe gets exactly one of `ack_o`/`nack_o`, as a one-cycle pulse in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | Bus START condition seen (one-cycle strobe) |
| stop_evt | input | 1 | Bus STOP condition seen (one-cycle strobe) |
| byte_valid | input | 1 | A received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| vp_flag | input | 1 | Programming voltage present on the shared pin |
| ack_o | output | 1 | Byte acknowledged (pulse) |
| nack_o | output | 1 | Byte not acknowledged (pulse) |
| prog_req_o | output | 3 | One-hot programming request per threshold |
| busy_o | output | 1 | Programming in progress |
| done_o | output | 1 | Programming completed (one-cycle pulse) |
| thr_codes_o | output | 3*CW | Stored threshold codes, threshold k at [k*CW +: CW] |

## Verification
Every result comes from one register stage. The acknowledge answer for a byte appears in the cycle after its strobe. Busy and the request follow one cycle after STOP. The completion strobe, the cleared busy flag and the new threshold code appear together one cycle after the edge that first samples `vp_flag` low. The bench drives inputs on falling edges, holds each strobe for exactly one cycle and samples at the next falling edge, so each result is read in the cycle it is due. The next falling edge also checks that the completion strobe has gone away. The main sweeps run every data value from 255 down to 0 and then from 0 up to 255 on each threshold. They also run every device byte value and every select byte value, and compare against a threshold model kept in the bench.

// File: rtl/tt_pkg.sv
package tt_pkg;

  localparam int NTHR = 3;
  localparam logic [7:0] DEV_WR_ADDR = 8'hA0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADR,
    ST_DAT,
    ST_HOLD,
    ST_SKIP,
    ST_PROG
  } seq_state_t;

  // Select byte to one-hot threshold index; zero when no threshold matches.
  function automatic logic [NTHR-1:0] thr_select(input logic [7:0] b);
    case (b)
      8'h03:   thr_select = 3'b001;
      8'h0B:   thr_select = 3'b010;
      8'h0F:   thr_select = 3'b100;
      default: thr_select = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/tt_byte_check.sv
module tt_byte_check
  import tt_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [7:0]      rx_byte,
  input  logic [CW-1:0]   cur_code,
  output logic            dev_ok,
  output logic [NTHR-1:0] sel_hit,
  output logic            data_reset,
  output logic            data_raise,
  output logic [CW-1:0]   new_code
);

  localparam logic [7:0] MAX_CODE = 8'((1 << CW) - 1);

  // A raise must stay within the code range and must not go below the present code.
  function automatic logic raise_ok(input logic [7:0] d, input logic [CW-1:0] cur);
    raise_ok = (d != 8'h00) && (d <= MAX_CODE) && (d[CW-1:0] >= cur);
  endfunction

  always_comb begin
    dev_ok     = (rx_byte == DEV_WR_ADDR);
    sel_hit    = thr_select(rx_byte);
    data_reset = (rx_byte == 8'h00);
    data_raise = raise_ok(rx_byte, cur_code);
    new_code   = rx_byte[CW-1:0];
  end

endmodule

// File: rtl/tt_thr_bank.sv
module tt_thr_bank #(
  parameter int NTHR      = 3,
  parameter int CW        = 5,
  parameter int INIT_CODE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NTHR-1:0]    wr_sel,
  input  logic [CW-1:0]      wr_code,
  input  logic [NTHR-1:0]    rd_sel,
  output logic [CW-1:0]      rd_code,
  output logic [NTHR*CW-1:0] codes_flat
);

  logic [CW-1:0] code_q [NTHR];

  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[k] <= CW'(INIT_CODE);
      else if (wr_en && wr_sel[k])
        code_q[k] <= wr_code;
    end
    assign codes_flat[k*CW +: CW] = code_q[k];
  end

  always_comb begin
    rd_code = '0;
    for (int k = 0; k < NTHR; k++)
      if (rd_sel[k]) rd_code = rd_code | code_q[k];
  end

endmodule

// File: rtl/tt_seq_fsm.sv
module tt_seq_fsm
  import tt_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic            byte_valid,
  input  logic            vp_flag,
  input  logic            dev_ok,
  input  logic [NTHR-1:0] sel_hit,
  input  logic            data_reset,
  input  logic            data_raise,
  input  logic [CW-1:0]   new_code,
  output logic            ack,
  output logic            nack,
  output logic            busy,
  output logic            done,
  output logic [NTHR-1:0] prog_req,
  output logic [NTHR-1:0] sel_q,
  output logic            wr_en,
  output logic [CW-1:0]   code_q
);

  seq_state_t state;

  // Completion: the programming pin seen low while busy.
  assign wr_en    = (state == ST_PROG) && !vp_flag;
  assign busy     = (state == ST_PROG);
  assign prog_req = busy ? sel_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sel_q  <= '0;
      code_q <= '0;
      ack    <= 1'b0;
      nack   <= 1'b0;
      done   <= 1'b0;
    end else begin
      ack  <= 1'b0;
      nack <= 1'b0;
      done <= 1'b0;
      if (state == ST_PROG) begin
        if (byte_valid) nack <= 1'b1;
        if (!vp_flag) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      end else if (start_evt) begin
        state <= vp_flag ? ST_DEV : ST_SKIP;
      end else if (stop_evt) begin
        state <= (state == ST_HOLD) ? ST_PROG : ST_IDLE;
      end else if (byte_valid) begin
        case (state)
          ST_DEV: begin
            if (dev_ok) begin
              ack   <= 1'b1;
              state <= ST_ADR;
            end else begin
              nack  <= 1'b1;
              state <= ST_SKIP;
            end
          end
          ST_ADR: begin
            if (sel_hit != '0) begin
              ack   <= 1'b1;
              sel_q <= sel_hit;
              state <= ST_DAT;
            end else begin
              nack  <= 1'b1;
              state <= ST_SKIP;
            end
          end
          ST_DAT: begin
            if (data_reset || data_raise) begin
              ack    <= 1'b1;
              code_q <= new_code;
              state  <= ST_HOLD;
            end else begin
              nack  <= 1'b1;
              state <= ST_SKIP;
            end
          end
          default: nack <= 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/tt_reset_seq.sv
module tt_reset_seq
  import tt_pkg::*;
#(
  parameter int CW        = 5,
  parameter int INIT_CODE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               byte_valid,
  input  logic [7:0]         rx_byte,
  input  logic               vp_flag,
  output logic               ack_o,
  output logic               nack_o,
  output logic [NTHR-1:0]    prog_req_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [NTHR*CW-1:0] thr_codes_o
);

  logic            dev_ok;
  logic [NTHR-1:0] sel_hit;
  logic            data_reset;
  logic            data_raise;
  logic [CW-1:0]   new_code;
  logic [NTHR-1:0] sel_q;
  logic [CW-1:0]   cur_code;
  logic [CW-1:0]   pend_code;
  logic            prog_done_evt;

  tt_byte_check #(.CW(CW)) u_check (
    .rx_byte    (rx_byte),
    .cur_code   (cur_code),
    .dev_ok     (dev_ok),
    .sel_hit    (sel_hit),
    .data_reset (data_reset),
    .data_raise (data_raise),
    .new_code   (new_code)
  );

  tt_seq_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .byte_valid (byte_valid),
    .vp_flag    (vp_flag),
    .dev_ok     (dev_ok),
    .sel_hit    (sel_hit),
    .data_reset (data_reset),
    .data_raise (data_raise),
    .new_code   (new_code),
    .ack        (ack_o),
    .nack       (nack_o),
    .busy       (busy_o),
    .done       (done_o),
    .prog_req   (prog_req_o),
    .sel_q      (sel_q),
    .wr_en      (prog_done_evt),
    .code_q     (pend_code)
  );

  tt_thr_bank #(.NTHR(NTHR), .CW(CW), .INIT_CODE(INIT_CODE)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (prog_done_evt),
    .wr_sel     (sel_q),
    .wr_code    (pend_code),
    .rd_sel     (sel_q),
    .rd_code    (cur_code),
    .codes_flat (thr_codes_o)
  );

endmodule

// File: rtl/tt_reset_seq_chk.sv
module tt_reset_seq_chk #(
  parameter int NTHR = 3,
  parameter int CW   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               byte_valid,
  input logic               vp_flag,
  input logic               ack_o,
  input logic               nack_o,
  input logic [NTHR-1:0]    prog_req_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [NTHR*CW-1:0] thr_codes_o,
  input logic               prog_done_evt
);

  // R11
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ack_o && nack_o));
  // R11
  byte_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> (ack_o || nack_o));
  // R5
  busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(prog_req_o) == 1));
  // R6
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_req_o == '0));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done_evt |=> (done_o && !busy_o));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && vp_flag) |=> busy_o);
  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && byte_valid) |=> nack_o);
  // R10
  thr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(thr_codes_o));

endmodule

bind tt_reset_seq tt_reset_seq_chk #(.NTHR(tt_pkg::NTHR), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_valid    (byte_valid),
  .vp_flag       (vp_flag),
  .ack_o         (ack_o),
  .nack_o        (nack_o),
  .prog_req_o    (prog_req_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .thr_codes_o   (thr_codes_o),
  .prog_done_evt (prog_done_evt)
);

// File: tb/test_tt_reset_seq.sv
module test_tt_reset_seq;

  localparam int CW   = 5;
  localparam int INIT = 16;
  localparam int MAXC = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_evt = 1'b0;
  logic        stop_evt = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        vp_flag = 1'b0;
  logic        ack_o, nack_o, busy_o, done_o;
  logic [2:0]  prog_req_o;
  logic [3*CW-1:0] thr_codes_o;

  int checks = 0;
  int errors = 0;
  int exp_thr [3];

  always #5 clk = ~clk;

  tt_reset_seq #(.CW(CW), .INIT_CODE(INIT)) i_tt_reset_seq (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .byte_valid(byte_valid), .rx_byte(rx_byte), .vp_flag(vp_flag),
    .ack_o(ack_o), .nack_o(nack_o), .prog_req_o(prog_req_o),
    .busy_o(busy_o), .done_o(done_o), .thr_codes_o(thr_codes_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input int k);
    return int'(thr_codes_o[k*CW +: CW]);
  endfunction

  task automatic chk_thr(input string tag);
    for (int k = 0; k < 3; k++)
      chk(thr_of(k) == exp_thr[k], tag, thr_of(k), exp_thr[k]);
  endtask

  task automatic do_start(input bit vp);
    @(negedge clk); start_evt = 1'b1; vp_flag = vp;
    @(negedge clk); start_evt = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  // Sends one byte; checks the answer in the cycle after the strobe (R11).
  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    @(negedge clk); byte_valid = 1'b1; rx_byte = b;
    @(negedge clk); byte_valid = 1'b0;
    chk(ack_o == exp_ack && nack_o == !exp_ack, tag, {ack_o, nack_o}, {exp_ack, !exp_ack});
  endtask

  // Drops the programming flag and checks completion timing (R6).
  task automatic finish(input int sel, input int code);
    @(negedge clk); vp_flag = 1'b0;
    @(negedge clk);
    exp_thr[sel] = code;
    chk(done_o && !busy_o && prog_req_o == 3'b000, "R6 done", {done_o, busy_o}, 2);
    chk_thr("R6 R10 threshold after completion");
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", done_o, 0);
  endtask

  // Full armed command on one threshold with model-computed expectations.
  task automatic do_cmd(input int sel, input int d);
    bit ok;
    logic [7:0] sb;
    sb = (sel == 0) ? 8'h03 : (sel == 1) ? 8'h0B : 8'h0F;
    ok = (d == 0) || (d <= MAXC && d >= exp_thr[sel]);
    do_start(1'b1);
    send(8'hA0, 1'b1, "R3 device byte");
    send(sb, 1'b1, "R4 select byte");
    send(8'(d), ok, (d == 0) ? "R5 reset data" : "R7 raise data");
    do_stop();
    if (ok) begin
      chk(busy_o && prog_req_o == 3'(1 << sel), "R5 busy request", prog_req_o, 1 << sel);
      finish(sel, d);
    end else begin
      chk(!busy_o, "R7 rejected no busy", busy_o, 0);
      @(negedge clk); vp_flag = 1'b0;
      chk_thr("R7 rejected unchanged");
    end
  endtask

  initial begin
    for (int k = 0; k < 3; k++) exp_thr[k] = INIT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !ack_o && !nack_o && prog_req_o == 0, "R1 reset outputs", busy_o, 0);
    chk_thr("R1 reset codes");

    // R2: flag raised after START does not arm.
    do_start(1'b0);
    @(negedge clk); vp_flag = 1'b1;
    send(8'hA0, 1'b0, "R2 unarmed device");
    send(8'h03, 1'b0, "R2 unarmed select");
    send(8'h00, 1'b0, "R2 unarmed data");
    do_stop();
    chk(!busy_o, "R2 no busy", busy_o, 0);
    @(negedge clk); vp_flag = 1'b0;
    chk_thr("R2 unchanged");

    // R3: every device byte value.
    for (int v = 0; v < 256; v++) begin
      do_start(1'b1);
      send(8'(v), v == 8'hA0, "R3 device sweep");
      if (v != 8'hA0) send(8'h03, 1'b0, "R3 ignored rest");
      do_stop();
      chk(!busy_o, "R3 R8 no busy", busy_o, 0);
    end

    // R4, R8: every select value, STOP before data.
    for (int v = 0; v < 256; v++) begin
      do_start(1'b1);
      send(8'hA0, 1'b1, "R4 device");
      send(8'(v), v == 8'h03 || v == 8'h0B || v == 8'h0F, "R4 select sweep");
      do_stop();
      chk(!busy_o, "R8 stop before data", busy_o, 0);
    end
    @(negedge clk); vp_flag = 1'b0;
    chk_thr("R8 unchanged");

    // R5, R7: data sweeps, descending then ascending, per threshold.
    for (int s = 0; s < 3; s++) begin
      for (int d = 255; d >= 0; d--) do_cmd(s, d);
      for (int d = 0; d < 256; d++) do_cmd(s, d);
    end

    // Put threshold 1 at 7, then R9 and R10 scenarios.
    do_cmd(1, 0);
    do_cmd(1, 7);
    do_start(1'b1);
    send(8'hA0, 1'b1, "R10 device");
    send(8'h0F, 1'b1, "R10 select");
    send(8'h00, 1'b1, "R10 data");
    send(8'h05, 1'b0, "R10 extra byte nacked");
    do_stop();
    chk(busy_o && prog_req_o == 3'b100, "R10 command still runs", prog_req_o, 4);
    do_start(1'b1);
    send(8'hA0, 1'b0, "R9 byte nacked while busy");
    chk(busy_o, "R9 start ignored", busy_o, 1);
    repeat (5) @(negedge clk);
    chk(busy_o && prog_req_o == 3'b100, "R9 holds while flag high", prog_req_o, 4);
    chk_thr("R10 unchanged while busy");
    finish(2, 0);
    chk(thr_of(1) == 7, "R10 other threshold kept", thr_of(1), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule